// File: doc/BRIEF.md
# Charge-Pump Clock Output Controller

This block produces the switching clock for a voltage-doubler charge pump. A small control space, written one 4-bit word at a time through a port-style write strobe, holds an enable, an output-pin choice, an idle-level polarity, a clamp-sense enable, a comparator threshold choice and a 4-bit rate code. The rate code divides the system clock by twice its value. The clock pulses stop whenever the voltage-sense flag reports that the divided doubled voltage has risen above the chosen threshold.

The clock leaves on one of two pads. Pad 0 is open-drain: it is driven only while low and released while high. Pad 1 is push-pull and drives an external transistor. Pad 2 is the sense pad. Any pad the block does not claim carries the general-purpose I/O data and direction unchanged. The analog comparator and the pad drivers are outside the block. The comparator result arrives as a synchronous bit, a high-impedance pad is shown as a deasserted output enable, and the threshold choice and comparator power enable are exported.

Top module: `cpclk_ctrl`

## Requirements
- R1: Reset clears every control field to 0. After reset, and while reset is held, every pad shows its general-purpose data and direction, and `cmp_pwr_en` and `cmp_thr_sel` are 0.
- R2: While the enable bit (address 0, bit 0) is 0, pads 0 and 1 pass `gpio_out` and `gpio_oe` unchanged.
- R3: With the enable bit set, the select bit (address 0, bit 1) claims pad 0 when 0 and pad 1 when 1. The claimed pad ignores its general-purpose values, and the other clock pad keeps them.
- R4: The polarity bit (address 0, bit 2) sets the idle level to its inverse: 1 means idle low, and 0 means idle high. The active level is the opposite of the idle level. Pad 1 always drives. Pad 0 drives low only and releases its output enable whenever the level is high.
- R5: A rate code c from 1 to 15 (address 1, bits 3:0) yields a clock with a period of 2c cycles. The first active phase begins on the c-th clock edge after the write.
- R6: Rate code 0 holds the claimed pad at the idle level from the edge that stores the code.
- R7: With sense enabled (address 2, bit 0), no new active phase starts while `sense_low` is 0, and pulses resume when it returns to 1. With sense disabled, the clock runs regardless of `sense_low`.
- R8: Dropping `sense_low` during an active phase does not shorten that phase. It lasts its full c cycles, and the output then stays idle.
- R9: Any write to the rate address restarts the divider count, so the next phase boundary falls c edges after that write.
- R10: With sense enabled, pad 2 is released (output enable 0, data 0) regardless of its general-purpose values, and `cmp_pwr_en` is 1. `cmp_thr_sel` follows address 2, bit 1.
- R11: Writes to address 3, and the value of address 0, bit 3, change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control write strobe |
| wr_addr | input | 2 | Control word address |
| wr_data | input | 4 | Control word data |
| sense_low | input | 1 | 1 while the sensed voltage is below the threshold |
| gpio_out | input | 3 | General-purpose output data per pad |
| gpio_oe | input | 3 | General-purpose output enable per pad |
| pad_out | output | 3 | Pad output data |
| pad_oe | output | 3 | Pad output enable (0 = high impedance) |
| cmp_pwr_en | output | 1 | Comparator power enable |
| cmp_thr_sel | output | 1 | Comparator threshold select |

## Verification
The bench measures the edge on which the first phase starts and ends for rate codes 1, 3 and 15. An off-by-one divider therefore shows up as a phase that moves by one cycle. It drops the sense flag in the middle of an active phase to catch a design that cuts the pulse short, and it rewrites the same rate code in the middle of a count to catch a divider that ignores the restart. A static table drives inverted and mixed general-purpose values into every pin mode. A mux that leaks port data onto a claimed pad, or that drives the open-drain pad high, produces a wrong pad word.

// File: rtl/cpclk_pkg.sv
package cpclk_pkg;
  localparam int CODE_W = 4;
  localparam int DATA_W = 4;
  localparam int ADDR_W = 2;
  localparam int NPAD   = 3;
  localparam int NCLK   = 2;
  localparam int OD_PAD = 0;
  localparam int SNS_PAD = 2;

  localparam logic [ADDR_W-1:0] ADR_MODE  = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_RATE  = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_SENSE = 2'd2;

  typedef struct packed {
    logic              thr_sel;
    logic              sense_en;
    logic              pol;
    logic              pin_sel;
    logic              clk_en;
    logic [CODE_W-1:0] code;
  } ctl_t;
endpackage

// File: rtl/cpclk_regs.sv
module cpclk_regs
  import cpclk_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output ctl_t          ctl,
  output logic          rate_wr
);
  ctl_t ctl_q, ctl_n;
  logic ctl_ce;

  always_comb begin
    ctl_n   = ctl_q;
    rate_wr = 1'b0;
    if (wr_en) begin
      case (wr_addr)
        ADR_MODE: begin
          ctl_n.clk_en  = wr_data[0];
          ctl_n.pin_sel = wr_data[1];
          ctl_n.pol     = wr_data[2];
        end
        ADR_RATE: begin
          ctl_n.code = wr_data[CODE_W-1:0];
          rate_wr    = 1'b1;
        end
        ADR_SENSE: begin
          ctl_n.sense_en = wr_data[0];
          ctl_n.thr_sel  = wr_data[1];
        end
        default: ;
      endcase
    end
  end

  assign ctl_ce = wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_ce) begin
      ctl_q <= ctl_n;
    end
  end

  assign ctl = ctl_q;
endmodule

// File: rtl/cpclk_div.sv
module cpclk_div #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en,
  input  logic          rate_wr,
  input  logic          gate_open,
  input  logic [CW-1:0] code,
  output logic          act
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          act_q, act_n;
  logic          live, term, div_ce;

  assign live = clk_en && (code != '0);
  assign term = (cnt_q == (code - ONE));

  always_comb begin
    cnt_n = cnt_q;
    act_n = act_q;
    if (!live) begin
      cnt_n = '0;
      act_n = 1'b0;
    end else if (rate_wr) begin
      cnt_n = '0;
    end else if (term) begin
      cnt_n = '0;
      act_n = act_q ? 1'b0 : gate_open;
    end else begin
      cnt_n = cnt_q + ONE;
    end
  end

  assign div_ce = live || act_q || (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (div_ce) begin
      cnt_q <= cnt_n;
      act_q <= act_n;
    end
  end

  assign act = act_q && live;
endmodule

// File: rtl/cpclk_pinmux.sv
module cpclk_pinmux #(
  parameter int NP   = 3,
  parameter int NC   = 2,
  parameter int ODP  = 0,
  parameter int SNSP = 2
) (
  input  logic          clk_en,
  input  logic          pin_sel,
  input  logic          pol,
  input  logic          sense_en,
  input  logic          act,
  input  logic [NP-1:0] gpio_out,
  input  logic [NP-1:0] gpio_oe,
  output logic [NP-1:0] pad_out,
  output logic [NP-1:0] pad_oe
);
  logic level;

  assign level = ~(act ^ pol);

  for (genvar g = 0; g < NC; g++) begin : g_clk
    logic claim;
    assign claim = clk_en && (pin_sel == 1'(g));
    if (g == ODP) begin : g_od
      assign pad_out[g] = claim ? level  : gpio_out[g];
      assign pad_oe[g]  = claim ? ~level : gpio_oe[g];
    end else begin : g_pp
      assign pad_out[g] = claim ? level : gpio_out[g];
      assign pad_oe[g]  = claim ? 1'b1  : gpio_oe[g];
    end
  end

  assign pad_out[SNSP] = sense_en ? 1'b0 : gpio_out[SNSP];
  assign pad_oe[SNSP]  = sense_en ? 1'b0 : gpio_oe[SNSP];
endmodule

// File: rtl/cpclk_ctrl.sv
module cpclk_ctrl
  import cpclk_pkg::*;
#(
  parameter int CW = CODE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [3:0]      wr_data,
  input  logic            sense_low,
  input  logic [2:0]      gpio_out,
  input  logic [2:0]      gpio_oe,
  output logic [2:0]      pad_out,
  output logic [2:0]      pad_oe,
  output logic            cmp_pwr_en,
  output logic            cmp_thr_sel
);
  logic [1:0]    rsync_q;
  logic          rst_n_s;
  ctl_t          ctl;
  logic          rate_wr;
  logic          act_q;
  logic          ctl_en, ctl_sel, ctl_pol, ctl_sense_en;
  logic [CW-1:0] ctl_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= '0;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_n_s = rsync_q[1];

  cpclk_regs #(.AW(ADDR_W), .DW(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ctl     (ctl),
    .rate_wr (rate_wr)
  );

  assign ctl_en       = ctl.clk_en;
  assign ctl_sel      = ctl.pin_sel;
  assign ctl_pol      = ctl.pol;
  assign ctl_sense_en = ctl.sense_en;
  assign ctl_code     = ctl.code;

  cpclk_div #(.CW(CW)) u_div (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .clk_en    (ctl_en),
    .rate_wr   (rate_wr),
    .gate_open (!ctl_sense_en || sense_low),
    .code      (ctl_code),
    .act       (act_q)
  );

  cpclk_pinmux #(.NP(NPAD), .NC(NCLK), .ODP(OD_PAD), .SNSP(SNS_PAD)) u_mux (
    .clk_en   (ctl_en),
    .pin_sel  (ctl_sel),
    .pol      (ctl_pol),
    .sense_en (ctl_sense_en),
    .act      (act_q),
    .gpio_out (gpio_out),
    .gpio_oe  (gpio_oe),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe)
  );

  assign cmp_pwr_en  = ctl_sense_en;
  assign cmp_thr_sel = ctl.thr_sel;
endmodule

// File: rtl/cpclk_ctrl_chk.sv
module cpclk_ctrl_chk (
  input logic       clk,
  input logic       rst_n_s,
  input logic       ctl_en,
  input logic       ctl_sel,
  input logic       ctl_pol,
  input logic       ctl_sense_en,
  input logic [3:0] ctl_code,
  input logic       act_q,
  input logic       sense_low,
  input logic [1:0] gpio_lo_out,
  input logic [1:0] gpio_lo_oe,
  input logic [2:0] pad_out,
  input logic [2:0] pad_oe
);
  assert_gpio_pass_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    !ctl_en |-> (pad_out[1:0] == gpio_lo_out && pad_oe[1:0] == gpio_lo_oe));

  assert_stop_code0_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ctl_en && ctl_code == 4'd0) |-> (pad_out[ctl_sel] == !ctl_pol));

  assert_open_drain_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ctl_en && !ctl_sel) |-> (pad_oe[0] != pad_out[0]));

  assert_gate_hold_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ctl_sense_en && !sense_low && !act_q) |=> !act_q);

  assert_sense_pad_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    ctl_sense_en |-> (!pad_oe[2] && !pad_out[2]));
endmodule

bind cpclk_ctrl cpclk_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n_s      (rst_n_s),
  .ctl_en       (ctl_en),
  .ctl_sel      (ctl_sel),
  .ctl_pol      (ctl_pol),
  .ctl_sense_en (ctl_sense_en),
  .ctl_code     (ctl_code),
  .act_q        (act_q),
  .sense_low    (sense_low),
  .gpio_lo_out  (gpio_out[1:0]),
  .gpio_lo_oe   (gpio_oe[1:0]),
  .pad_out      (pad_out),
  .pad_oe       (pad_oe)
);

// File: tb/sim_cpclk_ctrl.sv
module sim_cpclk_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [3:0] wr_data;
  logic       sense_low;
  logic [2:0] gpio_out, gpio_oe;
  logic [2:0] pad_out, pad_oe;
  logic       cmp_pwr_en, cmp_thr_sel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cpclk_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sense_low(sense_low), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
    .pad_out(pad_out), .pad_oe(pad_oe), .cmp_pwr_en(cmp_pwr_en), .cmp_thr_sel(cmp_thr_sel)
  );

  // mode[19:16] sense[15:14] gout[13:11] goe[10:8] eout[7:5] eoe[4:2] pwr[1] thr[0]
  localparam logic [19:0] VEC [7] = '{
    20'b0000_00_010_011_010_011_0_0,
    20'b0001_00_000_111_001_110_0_0,
    20'b0101_00_111_000_110_001_0_0,
    20'b0011_00_000_000_010_010_0_0,
    20'b0111_00_111_000_101_010_0_0,
    20'b0000_01_111_111_011_011_1_0,
    20'b1011_11_101_101_011_011_1_1
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic freq_test(input int c, input string req);
    wr(2'd1, 4'd0);
    step(1);
    wr(2'd1, 4'(c));
    step(c - 1);
    chk(req, 32'(pad_out[1]), 32'd0);
    step(1);
    chk(req, 32'(pad_out[1]), 32'd1);
    step(c - 1);
    chk(req, 32'(pad_out[1]), 32'd1);
    step(1);
    chk(req, 32'(pad_out[1]), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [2:0] so, soe;
    logic sp, st;
    int ones;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; sense_low = 1'b0;
    gpio_out = 3'b101; gpio_oe = 3'b110;
    step(3);
    rst_n = 1'b1;
    step(3);
    // R1 reset state
    chk("R1", {26'd0, pad_out, pad_oe}, {26'd0, 3'b101, 3'b110});
    chk("R1", {30'd0, cmp_pwr_en, cmp_thr_sel}, 32'd0);

    // static pin table: R2 R3 R4 R10
    for (int i = 0; i < 7; i++) begin
      wr(2'd1, 4'd0);
      wr(2'd0, VEC[i][19:16]);
      wr(2'd2, {2'b00, VEC[i][15:14]});
      gpio_out = VEC[i][13:11];
      gpio_oe  = VEC[i][10:8];
      step(1);
      chk((i == 0) ? "R2" : (i < 5) ? "R3/R4" : "R10",
          {24'd0, pad_out, pad_oe, cmp_pwr_en, cmp_thr_sel}, {24'd0, VEC[i][7:0]});
    end

    // R11 ignored writes
    wr(2'd2, 4'd0);
    wr(2'd0, 4'h7);
    gpio_out = 3'b010; gpio_oe = 3'b101;
    step(1);
    so = pad_out; soe = pad_oe; sp = cmp_pwr_en; st = cmp_thr_sel;
    wr(2'd3, 4'hF);
    step(2);
    chk("R11", {24'd0, pad_out, pad_oe, cmp_pwr_en, cmp_thr_sel}, {24'd0, so, soe, sp, st});
    wr(2'd0, 4'hF);
    step(2);
    chk("R11", {24'd0, pad_out, pad_oe, cmp_pwr_en, cmp_thr_sel}, {24'd0, so, soe, sp, st});

    // R5 frequency, pad 1 push-pull, positive polarity, sense off
    wr(2'd0, 4'h7);
    sense_low = 1'b0;
    freq_test(1, "R5");
    freq_test(3, "R5");
    freq_test(15, "R5");

    // R6 code 0 stops at once
    wr(2'd1, 4'd2);
    step(2);
    wr(2'd1, 4'd0);
    chk("R6", 32'(pad_out[1]), 32'd0);
    step(5);
    chk("R6", 32'(pad_out[1]), 32'd0);

    // R9 restart on rate write
    wr(2'd1, 4'd4);
    step(2);
    wr(2'd1, 4'd4);
    step(1);
    chk("R9", 32'(pad_out[1]), 32'd0);
    step(2);
    chk("R9", 32'(pad_out[1]), 32'd0);
    step(1);
    chk("R9", 32'(pad_out[1]), 32'd1);

    // R7 gating by sense flag
    wr(2'd1, 4'd0);
    step(1);
    wr(2'd2, 4'b0001);
    sense_low = 1'b0;
    wr(2'd1, 4'd2);
    ones = 0;
    for (int k = 0; k < 20; k++) begin step(1); ones += int'(pad_out[1]); end
    chk("R7", 32'(ones), 32'd0);
    sense_low = 1'b1;
    step(2);
    ones = 0;
    for (int k = 0; k < 16; k++) begin step(1); ones += int'(pad_out[1]); end
    chk("R7", 32'(ones), 32'd8);

    // R8 phase not shortened
    wr(2'd1, 4'd0);
    step(1);
    sense_low = 1'b1;
    wr(2'd1, 4'd4);
    step(3);
    chk("R8", 32'(pad_out[1]), 32'd0);
    step(1);
    chk("R8", 32'(pad_out[1]), 32'd1);
    sense_low = 1'b0;
    step(3);
    chk("R8", 32'(pad_out[1]), 32'd1);
    step(1);
    chk("R8", 32'(pad_out[1]), 32'd0);
    step(8);
    chk("R8", 32'(pad_out[1]), 32'd0);

    // R10 threshold and power
    wr(2'd2, 4'b0011);
    chk("R10", {30'd0, cmp_pwr_en, cmp_thr_sel}, 32'd3);
    wr(2'd2, 4'b0010);
    chk("R10", {30'd0, cmp_pwr_en, cmp_thr_sel}, 32'd1);

    // R1 reset in mid-run
    wr(2'd2, 4'b0001);
    sense_low = 1'b1;
    wr(2'd1, 4'd1);
    gpio_out = 3'b011; gpio_oe = 3'b100;
    step(3);
    rst_n = 1'b0;
    #1;
    chk("R1", {24'd0, pad_out, pad_oe, cmp_pwr_en, cmp_thr_sel}, {24'd0, 3'b011, 3'b100, 2'b00});
    step(2);
    rst_n = 1'b1;
    step(4);
    chk("R1", {24'd0, pad_out, pad_oe, cmp_pwr_en, cmp_thr_sel}, {24'd0, 3'b011, 3'b100, 2'b00});

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule